// File: doc/BRIEF.md
# Run-Time Coefficient Patch Controller

This block lets a host replace a run of coefficients in a DSP's coefficient RAM while the DSP program keeps executing. The host talks over a three-wire serial link: a framing strobe, a serial clock and a data line. The block answers on one ready line. In a first frame the host stages up to sixteen 16-bit words in a local buffer. In a second frame it names the start address of the run.

The controller does not write the run all at once. It watches the DSP's execution address. Each time that address equals the next pending target, it commits one staged word and moves the target up by one. The words therefore land in strict address order, and each one changes at the point in the program where it is used. If the program reaches a later address first, that visit is skipped. Ready stays low from the start command until every staged word is in RAM and a minimum low time has passed.

The RAM write side is a one-way strobe (`ram_we` with address and data) that has no back-pressure. The RAM must accept a write on every cycle the strobe is high. The host side has no flow control either. The host must watch `rdy` and only send a new command once `rdy` is high again. Commands that arrive while `rdy` is low are dropped.

Top module: `coef_patch_ctrl`

## Requirements
- R1: After reset, `rdy` is 1 and `ram_we` is 0.
- R2: In a frame whose first byte is 8'hA8, each following byte pair forms one staged word. The first byte of the pair is bits 15..8 and the second is bits 7..0. The committed `ram_wdata` equals that word.
- R3: A staging frame keeps only its first 16 words. Any later words in the same frame are dropped, and no write is ever made for them.
- R4: A frame whose first byte is 8'hA4 carries two address bytes. Bit 0 of the first byte is address bit 8. The second byte is address bits 7..0. Staged word k is written to start address + k.
- R5: A word is written only when `exec_addr` equals the pending target. `ram_we`, `ram_addr` and `ram_wdata` appear one clock after the matching cycle.
- R6: Writes follow strict ascending address order. If `exec_addr` shows a higher address of the run before the pending one, nothing is written on that visit.
- R7: After a start command, `rdy` stays low for at least max(2·(16−n), `min_low`) clock cycles, where n is the number of staged words. If all words were committed earlier, `rdy` is low for at most one cycle more than that.
- R8: `rdy` stays low until the last staged word has been written. It returns high within two clocks of that write, once the R7 minimum has passed.
- R9: A frame whose first byte is neither 8'hA8 nor 8'hA4 has no effect. An 8'hA4 frame sent when no words are staged also has no effect: `rdy` stays high and no write occurs.
- R10: Any frame that starts while `rdy` is low is ignored. It does not change the staged words that are still waiting to be written.
- R11: `sdi` is sampled MSB first on each rising edge of `sclk` while `req` is high. Bringing `req` low resets the byte framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host frame strobe, high during a command frame |
| sclk | input | 1 | Host serial clock (asynchronous) |
| sdi | input | 1 | Host serial data |
| rdy | output | 1 | High when a new command is accepted |
| min_low | input | 8 | Minimum ready-low width in clock cycles |
| exec_addr | input | 9 | Current DSP coefficient execution address |
| ram_we | output | 1 | Coefficient RAM write strobe |
| ram_addr | output | 9 | Coefficient RAM write address |
| ram_wdata | output | 16 | Coefficient RAM write data |

## Verification
Wrong internal state shows up at the RAM port within one clock of the DSP visiting an address. A bad target counter writes at the wrong visit or skips one. A bad buffer index puts the wrong word on `ram_wdata`. A stuck decoder leaves `rdy` high after a start frame. A faulty timer or completion test shows as a ready-low interval that is too short, too long, or ends before the last write. The bench uses a scoreboard that checks each write against a queue of expected address and data pairs. It also measures every ready-low interval against the R7 bound.

// File: rtl/coef_patch_pkg.sv
package coef_patch_pkg;
  localparam logic [7:0] CMD_STAGE = 8'hA8;
  localparam logic [7:0] CMD_START = 8'hA4;
  localparam int CRAM_AW = 9;

  typedef enum logic [2:0] {
    DEC_CMD,
    DEC_WHI,
    DEC_WLO,
    DEC_AHI,
    DEC_ALO,
    DEC_SKIP
  } dec_state_t;
endpackage

// File: rtl/patch_serial_rx.sv
module patch_serial_rx #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       sclk,
  input  logic       sdi,
  output logic       frame_act,
  output logic       byte_vld,
  output logic [7:0] byte_dat
);
  logic [SYNC-1:0] req_q, sclk_q, sdi_q;
  logic            sclk_d;
  logic [2:0]      bit_cnt;
  logic [6:0]      shreg;
  logic            rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      sclk_q <= '0;
      sdi_q  <= '0;
      sclk_d <= 1'b0;
    end else begin
      req_q  <= {req_q[SYNC-2:0], req};
      sclk_q <= {sclk_q[SYNC-2:0], sclk};
      sdi_q  <= {sdi_q[SYNC-2:0], sdi};
      sclk_d <= sclk_q[SYNC-1];
    end
  end

  assign frame_act = req_q[SYNC-1];
  assign rise      = sclk_q[SYNC-1] & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!frame_act) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shreg   <= {shreg[5:0], sdi_q[SYNC-1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_dat <= {shreg, sdi_q[SYNC-1]};
        end
      end
    end
  end
endmodule

// File: rtl/patch_stage_buf.sv
module patch_stage_buf
  import coef_patch_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_act,
  input  logic               byte_vld,
  input  logic [7:0]         byte_dat,
  input  logic               busy,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [WORD_W-1:0]  rd_word,
  output logic               start,
  output logic [CRAM_AW-1:0] start_addr,
  output logic [CNT_W-1:0]   start_cnt
);
  dec_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        hi_byte;
  logic              a_top;
  logic [WORD_W-1:0] mem [DEPTH];
  logic              wr_en;

  assign wr_en = frame_act && byte_vld && (state == DEC_WLO) && (cnt < CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en) mem[cnt[IDX_W-1:0]] <= WORD_W'({hi_byte, byte_dat});
  end

  assign rd_word = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= DEC_CMD;
      cnt        <= '0;
      hi_byte    <= '0;
      a_top      <= 1'b0;
      start      <= 1'b0;
      start_addr <= '0;
      start_cnt  <= '0;
    end else begin
      start <= 1'b0;
      if (!frame_act) begin
        state <= DEC_CMD;
      end else if (byte_vld) begin
        unique case (state)
          DEC_CMD: begin
            if (busy)                        state <= DEC_SKIP;
            else if (byte_dat == CMD_STAGE) begin
              cnt   <= '0;
              state <= DEC_WHI;
            end
            else if (byte_dat == CMD_START)  state <= DEC_AHI;
            else                             state <= DEC_SKIP;
          end
          DEC_WHI: begin
            hi_byte <= byte_dat;
            state   <= DEC_WLO;
          end
          DEC_WLO: begin
            if (wr_en) cnt <= cnt + 1'b1;
            state <= DEC_WHI;
          end
          DEC_AHI: begin
            a_top <= byte_dat[0];
            state <= DEC_ALO;
          end
          DEC_ALO: begin
            if (cnt != '0) begin
              start      <= 1'b1;
              start_addr <= {a_top, byte_dat};
              start_cnt  <= cnt;
              cnt        <= '0;
            end
            state <= DEC_SKIP;
          end
          default: state <= DEC_SKIP;
        endcase
      end
    end
  end
endmodule

// File: rtl/patch_commit_seq.sv
module patch_commit_seq
  import coef_patch_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  parameter int MINW_W = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int BASE_W = $clog2(2 * DEPTH + 1),
  localparam int TW     = (MINW_W > BASE_W) ? MINW_W : BASE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CRAM_AW-1:0] start_addr,
  input  logic [CNT_W-1:0]   start_cnt,
  input  logic [MINW_W-1:0]  min_low,
  input  logic [CRAM_AW-1:0] exec_addr,
  input  logic [WORD_W-1:0]  rd_word,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               busy,
  output logic               ram_we,
  output logic [CRAM_AW-1:0] ram_addr,
  output logic [WORD_W-1:0]  ram_wdata
);
  logic [CRAM_AW-1:0] tgt;
  logic [CNT_W-1:0]   idx, n;
  logic [TW-1:0]      timer, base_w, load_w;
  logic               done, hit;

  always_comb begin
    base_w = TW'(2 * (DEPTH - int'(start_cnt)));
    load_w = (base_w > TW'(min_low)) ? base_w : TW'(min_low);
  end

  assign done   = (idx == n);
  assign hit    = busy && !done && (exec_addr == tgt);
  assign rd_idx = idx[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tgt       <= '0;
      idx       <= '0;
      n         <= '0;
      timer     <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        tgt   <= start_addr;
        idx   <= '0;
        n     <= start_cnt;
        timer <= load_w;
      end else if (busy) begin
        if (timer != '0) timer <= timer - 1'b1;
        if (hit) begin
          ram_we    <= 1'b1;
          ram_addr  <= tgt;
          ram_wdata <= rd_word;
          tgt       <= tgt + 1'b1;
          idx       <= idx + 1'b1;
        end
        if (done && timer == '0) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/coef_patch_ctrl.sv
module coef_patch_ctrl
  import coef_patch_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  parameter int MINW_W = 8,
  parameter int SYNC   = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               sclk,
  input  logic               sdi,
  output logic               rdy,
  input  logic [MINW_W-1:0]  min_low,
  input  logic [CRAM_AW-1:0] exec_addr,
  output logic               ram_we,
  output logic [CRAM_AW-1:0] ram_addr,
  output logic [WORD_W-1:0]  ram_wdata
);
  logic               frame_act, byte_vld, busy, start;
  logic [7:0]         byte_dat;
  logic [IDX_W-1:0]   rd_idx;
  logic [WORD_W-1:0]  rd_word;
  logic [CRAM_AW-1:0] start_addr;
  logic [CNT_W-1:0]   start_cnt;

  patch_serial_rx #(.SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .req(req), .sclk(sclk), .sdi(sdi),
    .frame_act(frame_act), .byte_vld(byte_vld), .byte_dat(byte_dat)
  );

  patch_stage_buf #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .busy(busy), .rd_idx(rd_idx), .rd_word(rd_word),
    .start(start), .start_addr(start_addr), .start_cnt(start_cnt)
  );

  patch_commit_seq #(.DEPTH(DEPTH), .WORD_W(WORD_W), .MINW_W(MINW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_cnt(start_cnt), .min_low(min_low), .exec_addr(exec_addr),
    .rd_word(rd_word), .rd_idx(rd_idx), .busy(busy), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  assign rdy = ~busy;
endmodule

// File: rtl/coef_patch_chk.sv
module coef_patch_chk #(
  parameter int MINW_W = 8,
  parameter int AW     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdy,
  input logic              ram_we,
  input logic [AW-1:0]     ram_addr,
  input logic [AW-1:0]     exec_addr,
  input logic [MINW_W-1:0] min_low
);
  logic [15:0]   low_cnt;
  logic          seen_prev;
  logic [AW-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      seen_prev <= 1'b0;
      prev_addr <= '0;
    end else begin
      if (rdy) low_cnt <= '0;
      else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
      if (rdy) seen_prev <= 1'b0;
      else if (ram_we) begin
        seen_prev <= 1'b1;
        prev_addr <= ram_addr;
      end
    end
  end

  AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> !rdy); // R8
  AST_WE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> ram_addr == $past(exec_addr)); // R5
  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n) (ram_we && seen_prev) |-> ram_addr == prev_addr + 1'b1); // R6
  AST_NO_WE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rdy) |-> !ram_we); // R8
  AST_MIN_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(rdy) |-> low_cnt >= 16'(min_low)); // R7
endmodule

bind coef_patch_ctrl coef_patch_chk #(.MINW_W(MINW_W), .AW(coef_patch_pkg::CRAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .ram_we(ram_we), .ram_addr(ram_addr),
  .exec_addr(exec_addr), .min_low(min_low)
);

// File: tb/coef_patch_ctrl_bench.sv
module coef_patch_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic        rdy, ram_we;
  logic [7:0]  min_low = 8'd0;
  logic [8:0]  exec_addr = 9'h100;
  logic [8:0]  ram_addr;
  logic [15:0] ram_wdata;

  int vectors = 0, fails = 0;
  logic [24:0] exp_q [$];
  logic [15:0] wbuf [20];
  int  exp_low = 0;
  bit  chk_low = 0;
  bit  finished = 0;
  int  low_len = 0;

  always #2.5 clk = ~clk;

  coef_patch_ctrl u_coef_patch_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .sclk(sclk), .sdi(sdi), .rdy(rdy),
    .min_low(min_low), .exec_addr(exec_addr), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on each write, ready-low width measurement
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (ram_we) begin
        if (exp_q.size() == 0) check(0, "R5/R6 unexpected write", {ram_addr, ram_wdata}, 0);
        else begin
          logic [24:0] e;
          e = exp_q.pop_front();
          check({ram_addr, ram_wdata} == e, "R2/R4/R5 write", {ram_addr, ram_wdata}, e);
        end
      end
      if (!rdy) low_len++;
      else if (low_len != 0) begin
        if (chk_low) check(low_len >= exp_low && low_len <= exp_low + 1, "R7 low width", low_len, exp_low);
        low_len = 0;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic stage_frame(input int nw);
    req = 1'b1;
    repeat (4) @(negedge clk);
    send_byte(8'hA8);
    for (int k = 0; k < nw; k++) begin
      send_byte(wbuf[k][15:8]);
      send_byte(wbuf[k][7:0]);
    end
    repeat (4) @(negedge clk);
    req = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic two_byte_frame(input logic [7:0] c, input logic [7:0] hi, input logic [7:0] lo);
    req = 1'b1;
    repeat (4) @(negedge clk);
    send_byte(c);
    send_byte(hi);
    send_byte(lo);
    repeat (4) @(negedge clk);
    req = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_rdy_low();
    for (int t = 0; t < 2000 && rdy; t++) @(negedge clk);
  endtask

  task automatic wait_rdy_high();
    for (int t = 0; t < 2000 && !rdy; t++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int seq_a [12] = '{7, 8, 9, 10, 11, 13, 16, 11, 12, 13, 14, 15};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdy == 1'b1, "R1 rdy", rdy, 1);
    check(ram_we == 1'b0, "R1 ram_we", ram_we, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Test A: five words at 10; out-of-order visits (R5 R6 R11); low width 22 (R7)
    for (int k = 0; k < 5; k++) wbuf[k] = 16'h1234 + 16'(k * 16'h1111);
    stage_frame(5);
    for (int k = 0; k < 5; k++) exp_q.push_back({9'(10 + k), wbuf[k]});
    exp_low = 22; chk_low = 1;
    fork
      two_byte_frame(8'hA4, 8'h00, 8'd10);
      begin
        wait_rdy_low();
        for (int i = 0; i < 12; i++) begin exec_addr = 9'(seq_a[i]); @(negedge clk); end
        exec_addr = 9'h100;
      end
    join
    wait_rdy_high();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 all A words", exp_q.size(), 0);

    // Test B: 18 words sent, 16 kept (R3); address bit 8 (R4); min_low 60 (R7)
    for (int k = 0; k < 18; k++) wbuf[k] = 16'hC000 ^ 16'(k * 16'h0313);
    stage_frame(18);
    for (int k = 0; k < 16; k++) exp_q.push_back({9'h1F0 + 9'(k), wbuf[k]});
    min_low = 8'd60; exp_low = 60;
    fork
      two_byte_frame(8'hA4, 8'h01, 8'hF0);
      begin
        wait_rdy_low();
        for (int i = 0; i < 20; i++) begin exec_addr = 9'h1F0 + 9'(i); @(negedge clk); end
        exec_addr = 9'h100;
      end
    join
    wait_rdy_high();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 sixteen writes", exp_q.size(), 0);

    // Test C: slow commits hold rdy low (R8); frame during busy rejected (R10)
    min_low = 8'd0; chk_low = 0;
    wbuf[0] = 16'hBEEF; wbuf[1] = 16'hCAFE;
    stage_frame(2);
    exp_q.push_back({9'h040, 16'hBEEF});
    exp_q.push_back({9'h041, 16'hCAFE});
    two_byte_frame(8'hA4, 8'h00, 8'h40);
    wait_rdy_low();
    wbuf[0] = 16'h0BAD; wbuf[1] = 16'hDEAD;
    stage_frame(2);
    check(rdy == 1'b0, "R8 rdy low while pending", rdy, 0);
    exec_addr = 9'h040; @(negedge clk);
    exec_addr = 9'h041; @(negedge clk);
    exec_addr = 9'h100;
    repeat (2) @(negedge clk);
    check(rdy == 1'b1, "R8 rdy high after last write", rdy, 1);
    check(exp_q.size() == 0, "R10 original data kept", exp_q.size(), 0);

    // Test D: unknown command and start with nothing staged (R9)
    two_byte_frame(8'h55, 8'h00, 8'h20);
    check(rdy == 1'b1, "R9 unknown command", rdy, 1);
    exec_addr = 9'h020;
    two_byte_frame(8'hA4, 8'h00, 8'h20);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(rdy == 1'b1, "R9 empty start", rdy, 1);
    end
    exec_addr = 9'h100;

    // Test E: req drop mid-byte resets framing (R11)
    req = 1'b1; repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; repeat (4) @(negedge clk); sclk = 1'b1; repeat (4) @(negedge clk); sclk = 1'b0;
    end
    req = 1'b0; repeat (6) @(negedge clk);
    wbuf[0] = 16'h7E81;
    stage_frame(1);
    exp_q.push_back({9'h005, 16'h7E81});
    exp_low = 30; chk_low = 1;
    fork
      two_byte_frame(8'hA4, 8'h00, 8'h05);
      begin
        wait_rdy_low();
        exec_addr = 9'h005; @(negedge clk);
        exec_addr = 9'h100;
      end
    join
    wait_rdy_high();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 framing after abort", exp_q.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule